// File: doc/BRIEF.md
# Oscillator and PLL Power Sequencer

This block owns two general-purpose output pins: one powers a crystal oscillator, the other is an active-high power-down control for a PLL. A client issues a power-up or power-down command together with a two-bit select that names the oscillator, the PLL, or both. The block updates its output-value and output-enable registers in the required order. During power-up it holds the settle delays, counted in milliseconds by a prescaler that is derived from the clock-frequency parameter.

During power-up the block samples the oscillator pin through a small synchronizer. If the oscillator already reads as running, the pin values are left alone so that a clock another agent depends on is not glitched. Every power-up command ends with a one-cycle pulse that clears a sticky signalled-target-abort status bit elsewhere in the chip. Every command ends with a one-cycle done pulse. A command that arrives while a settle delay is running is refused and flagged.

Top module: `osc_pll_seq`

## Requirements
- R1: After reset, `gpio_out` and `gpio_oe` are all zero, and `busy`, `done`, `abort_clr` and `cmd_reject` are low.
- R2: Every accepted command sets the output-enable bit of each selected pin and clears no enable bit. Select bit 0 names the oscillator pin at position `OSC_IDX` (default 2). Select bit 1 names the PLL pin at position `PLL_IDX` (default 3). All other bits of `gpio_out` and `gpio_oe` never change.
- R3: A power-down command (`cmd_on`=0) clears the oscillator bit if it is selected and sets the PLL bit if it is selected. Both take effect together in the cycle after acceptance, together with a `done` pulse. `busy` stays low.
- R4: A power-up command accepted while the synchronized oscillator sense reads 1 changes no bit of `gpio_out`. `done` and `abort_clr` pulse in the cycle after acceptance.
- R5: A power-up command with the oscillator selected and the sense reading 0 drives the oscillator bit high in the cycle after acceptance. If the PLL is also selected, the PLL bit is driven high in the same cycle. `busy` then stays high for `OSC_MS` milliseconds.
- R6: When the PLL was selected with the oscillator, the PLL bit is cleared when the oscillator delay ends, followed by a further `PLL_MS` milliseconds of `busy`. The oscillator bit does not change while `busy` is high.
- R7: A power-up command that selects only the PLL, with the sense reading 0, clears the PLL bit in the cycle after acceptance and holds `busy` for `PLL_MS` milliseconds.
- R8: Once a power-up finishes, `busy` is low, and `done` and `abort_clr` are high together for exactly one cycle.
- R9: A command presented while `busy` is high is ignored: pins and enables do not change, and `cmd_reject` pulses in the following cycle.
- R10: One millisecond equals `CLK_HZ/1000` clock cycles. Over a power-up, `busy` stays high for exactly that many cycles per millisecond of delay.
- R11: A power-up command with an empty select changes no pin and finishes at once with `done` and `abort_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_on | input | 1 | 1 = power up, 0 = power down |
| cmd_sel | input | 2 | Bit 0 oscillator, bit 1 PLL |
| osc_sense | input | 1 | Sensed oscillator pin level (asynchronous) |
| gpio_out | output | GPIO_W | Output-value register |
| gpio_oe | output | GPIO_W | Output-enable register |
| busy | output | 1 | A settle delay is running |
| done | output | 1 | One-cycle end-of-command pulse |
| abort_clr | output | 1 | One-cycle pulse clearing the target-abort status |
| cmd_reject | output | 1 | One-cycle pulse for a refused command |

## Verification
On every cycle the assertions check the following: enable bits never fall, the enables and the oscillator bit hold while `busy` is high, a command seen while busy is followed by a reject pulse, and the fall of `busy` coincides with `done` and `abort_clr`. The order in which the pin values evolve, the skip when the oscillator is sensed running, and the exact millisecond cycle counts depend on the command history. Only the bench scenarios show these, by comparing against a model of the pin registers at the acceptance cycle, at the PLL release and at completion.

// File: rtl/osc_pll_pkg.sv
package osc_pll_pkg;
   typedef enum logic [1:0] {
      RT_FIN_OFF,
      RT_FIN_ON,
      RT_OSC_WAIT,
      RT_PLL_WAIT
   } route_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_OSC,
      ST_PLL
   } state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/osc_pll_ms_timer.sv
module osc_pll_ms_timer #(
   parameter int CPM   = 1000,
   parameter int CYC_W = 10,
   parameter int MS_W  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [MS_W-1:0] target,
   output logic            expire
);
   logic [CYC_W-1:0] cyc_q;
   logic [MS_W-1:0]  ms_q;
   logic             ms_edge;

   assign ms_edge = (cyc_q == CYC_W'(CPM - 1));
   assign expire  = run && ms_edge && (ms_q == (target - MS_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         ms_q  <= '0;
      end else if (!run || expire) begin
         cyc_q <= '0;
         ms_q  <= '0;
      end else if (ms_edge) begin
         cyc_q <= '0;
         ms_q  <= ms_q + MS_W'(1);
      end else begin
         cyc_q <= cyc_q + CYC_W'(1);
      end
   end
endmodule

// File: rtl/osc_pll_pin_plan.sv
module osc_pll_pin_plan
   import osc_pll_pkg::*;
#(
   parameter int GPIO_W  = 8,
   parameter int OSC_IDX = 2,
   parameter int PLL_IDX = 3
) (
   input  logic [GPIO_W-1:0] cur_out,
   input  logic [GPIO_W-1:0] cur_oe,
   input  logic              on,
   input  logic [1:0]        sel,
   input  logic              sense,
   output logic [GPIO_W-1:0] nxt_out,
   output logic [GPIO_W-1:0] nxt_oe,
   output route_e            route
);
   logic [GPIO_W-1:0] sel_mask;

   always_comb begin
      sel_mask          = '0;
      sel_mask[OSC_IDX] = sel[0];
      sel_mask[PLL_IDX] = sel[1];
   end

   assign nxt_oe = cur_oe | sel_mask;

   always_comb begin
      nxt_out = cur_out;
      route   = RT_FIN_ON;
      if (!on) begin
         route = RT_FIN_OFF;
         if (sel[0]) nxt_out[OSC_IDX] = 1'b0;
         if (sel[1]) nxt_out[PLL_IDX] = 1'b1;
      end else if (sense) begin
         route = RT_FIN_ON;
      end else if (sel[0]) begin
         route = RT_OSC_WAIT;
         nxt_out[OSC_IDX] = 1'b1;
         if (sel[1]) nxt_out[PLL_IDX] = 1'b1;
      end else if (sel[1]) begin
         route = RT_PLL_WAIT;
         nxt_out[PLL_IDX] = 1'b0;
      end
   end
endmodule

// File: rtl/osc_pll_ctrl.sv
module osc_pll_ctrl
   import osc_pll_pkg::*;
#(
   parameter int GPIO_W  = 8,
   parameter int PLL_IDX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_on,
   input  logic              pll_sel,
   input  logic [GPIO_W-1:0] plan_out,
   input  logic [GPIO_W-1:0] plan_oe,
   input  route_e            plan_route,
   input  logic              expire,
   output logic [GPIO_W-1:0] out_q,
   output logic [GPIO_W-1:0] oe_q,
   output logic              in_wait,
   output logic              pll_phase,
   output logic              done_q,
   output logic              abort_q,
   output logic              reject_q
);
   state_e state_q;
   logic   pll_after_q;

   assign in_wait   = (state_q != ST_IDLE);
   assign pll_phase = (state_q == ST_PLL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         out_q       <= '0;
         oe_q        <= '0;
         pll_after_q <= 1'b0;
         done_q      <= 1'b0;
         abort_q     <= 1'b0;
         reject_q    <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         abort_q  <= 1'b0;
         reject_q <= cmd_valid && (state_q != ST_IDLE);
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  out_q       <= plan_out;
                  oe_q        <= plan_oe;
                  pll_after_q <= cmd_on && pll_sel;
                  unique case (plan_route)
                     RT_FIN_OFF: done_q <= 1'b1;
                     RT_FIN_ON: begin
                        done_q  <= 1'b1;
                        abort_q <= 1'b1;
                     end
                     RT_OSC_WAIT: state_q <= ST_OSC;
                     RT_PLL_WAIT: state_q <= ST_PLL;
                     default: state_q <= ST_IDLE;
                  endcase
               end
            end
            ST_OSC: begin
               if (expire) begin
                  if (pll_after_q) begin
                     out_q[PLL_IDX] <= 1'b0;
                     state_q        <= ST_PLL;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     abort_q <= 1'b1;
                  end
               end
            end
            ST_PLL: begin
               if (expire) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  abort_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/osc_pll_seq.sv
module osc_pll_seq
   import osc_pll_pkg::*;
#(
   parameter int GPIO_W      = 8,
   parameter int OSC_IDX     = 2,
   parameter int PLL_IDX     = 3,
   parameter int CLK_HZ      = 100_000_000,
   parameter int OSC_MS      = 1,
   parameter int PLL_MS      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_on,
   input  logic [1:0]        cmd_sel,
   input  logic              osc_sense,
   output logic [GPIO_W-1:0] gpio_out,
   output logic [GPIO_W-1:0] gpio_oe,
   output logic              busy,
   output logic              done,
   output logic              abort_clr,
   output logic              cmd_reject
);
   localparam int CPM    = CLK_HZ / 1000;
   localparam int CYC_W  = (CPM > 1) ? $clog2(CPM) : 1;
   localparam int MS_MAX = max_int(OSC_MS, PLL_MS);
   localparam int MS_W   = $clog2(MS_MAX + 1);

   if (CPM < 1) begin : g_bad_clk
      $error("CLK_HZ must be at least 1000");
   end
   if (OSC_MS < 1 || PLL_MS < 1) begin : g_bad_ms
      $error("settle delays must be at least 1 ms");
   end
   if (OSC_IDX == PLL_IDX || OSC_IDX >= GPIO_W || PLL_IDX >= GPIO_W
       || OSC_IDX < 0 || PLL_IDX < 0) begin : g_bad_idx
      $error("pin indices must be distinct and inside GPIO_W");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic sense_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sense_s = osc_sense;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else begin
            sh_q[0] <= osc_sense;
            for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
         end
      end
      assign sense_s = sh_q[SYNC_STAGES-1];
   end

   logic [GPIO_W-1:0] plan_out, plan_oe;
   route_e            plan_route;
   logic              expire, in_wait, pll_phase;
   logic [MS_W-1:0]   target;

   osc_pll_pin_plan #(
      .GPIO_W (GPIO_W),
      .OSC_IDX(OSC_IDX),
      .PLL_IDX(PLL_IDX)
   ) u_plan (
      .cur_out(gpio_out),
      .cur_oe (gpio_oe),
      .on     (cmd_on),
      .sel    (cmd_sel),
      .sense  (sense_s),
      .nxt_out(plan_out),
      .nxt_oe (plan_oe),
      .route  (plan_route)
   );

   osc_pll_ctrl #(
      .GPIO_W (GPIO_W),
      .PLL_IDX(PLL_IDX)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_on    (cmd_on),
      .pll_sel   (cmd_sel[1]),
      .plan_out  (plan_out),
      .plan_oe   (plan_oe),
      .plan_route(plan_route),
      .expire    (expire),
      .out_q     (gpio_out),
      .oe_q      (gpio_oe),
      .in_wait   (in_wait),
      .pll_phase (pll_phase),
      .done_q    (done),
      .abort_q   (abort_clr),
      .reject_q  (cmd_reject)
   );

   assign target = pll_phase ? MS_W'(PLL_MS) : MS_W'(OSC_MS);
   assign busy   = in_wait;

   osc_pll_ms_timer #(
      .CPM  (CPM),
      .CYC_W(CYC_W),
      .MS_W (MS_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_wait),
      .target(target),
      .expire(expire)
   );
endmodule

// File: rtl/osc_pll_seq_chk.sv
module osc_pll_seq_chk #(
   parameter int GPIO_W  = 8,
   parameter int OSC_IDX = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [GPIO_W-1:0] gpio_out,
   input logic [GPIO_W-1:0] gpio_oe,
   input logic              busy,
   input logic              done,
   input logic              abort_clr,
   input logic              cmd_reject
);
   p_oe_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((gpio_oe & $past(gpio_oe)) == $past(gpio_oe)));

   p_oe_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(gpio_oe));

   p_osc_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(gpio_out[OSC_IDX]));

   p_reject_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy) |=> cmd_reject);

   p_reject_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> $past(busy));

   p_end_pulses_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && abort_clr));

   p_abort_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_clr |-> done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind osc_pll_seq osc_pll_seq_chk #(
   .GPIO_W (GPIO_W),
   .OSC_IDX(OSC_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .gpio_out  (gpio_out),
   .gpio_oe   (gpio_oe),
   .busy      (busy),
   .done      (done),
   .abort_clr (abort_clr),
   .cmd_reject(cmd_reject)
);

// File: tb/tb_osc_pll_seq.sv
module tb_osc_pll_seq;
   localparam int W    = 8;
   localparam int OSC  = 2;
   localparam int PLL  = 3;
   localparam int HZ   = 10_000;
   localparam int CPM  = HZ / 1000;
   localparam int OMS  = 1;
   localparam int PMS  = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_on = 1'b0;
   logic [1:0]   cmd_sel = 2'b00;
   logic         osc_sense = 1'b0;
   logic [W-1:0] gpio_out, gpio_oe;
   logic         busy, done, abort_clr, cmd_reject;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] m_out = '0;
   logic [W-1:0] m_oe  = '0;

   always #2.5 clk = ~clk;

   osc_pll_seq #(
      .GPIO_W(W), .OSC_IDX(OSC), .PLL_IDX(PLL), .CLK_HZ(HZ),
      .OSC_MS(OMS), .PLL_MS(PMS), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
      .cmd_sel(cmd_sel), .osc_sense(osc_sense), .gpio_out(gpio_out),
      .gpio_oe(gpio_oe), .busy(busy), .done(done), .abort_clr(abort_clr),
      .cmd_reject(cmd_reject)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] sel_mask(input logic [1:0] sel);
      logic [W-1:0] m = '0;
      m[OSC] = sel[0];
      m[PLL] = sel[1];
      return m;
   endfunction

   function automatic logic [W-1:0] exp_first(input logic [W-1:0] cur, input bit on,
                                              input logic [1:0] sel, input bit sense);
      logic [W-1:0] r = cur;
      if (!on) begin
         if (sel[0]) r[OSC] = 1'b0;
         if (sel[1]) r[PLL] = 1'b1;
      end else if (!sense) begin
         if (sel[0]) begin
            r[OSC] = 1'b1;
            if (sel[1]) r[PLL] = 1'b1;
         end else if (sel[1]) begin
            r[PLL] = 1'b0;
         end
      end
      return r;
   endfunction

   function automatic int exp_busy(input bit on, input logic [1:0] sel, input bit sense);
      if (!on || sense) return 0;
      if (sel[0]) return CPM * (OMS + (sel[1] ? PMS : 0));
      if (sel[1]) return CPM * PMS;
      return 0;
   endfunction

   task automatic run_cmd(input bit on, input logic [1:0] sel, input bit sense,
                          input bit poke, input string tag);
      logic [W-1:0] first, fin, eoe;
      int b;
      osc_sense = sense;
      repeat (3) @(negedge clk);
      first = exp_first(m_out, on, sel, sense);
      b     = exp_busy(on, sel, sense);
      fin   = first;
      if (on && !sense && sel == 2'b11) fin[PLL] = 1'b0;
      eoe   = m_oe | sel_mask(sel);
      cmd_on = on; cmd_sel = sel; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(gpio_out == first, {tag, " pins after accept"}, 32'(gpio_out), 32'(first));
      check(gpio_oe == eoe, "R2 enables after accept", 32'(gpio_oe), 32'(eoe));
      check(busy == (b > 0), {tag, " busy after accept"}, 32'(busy), 32'(b > 0));
      check(done == (b == 0), {tag, " done after accept"}, 32'(done), 32'(b == 0));
      check(abort_clr == (on && b == 0), {tag, " abort pulse after accept"},
            32'(abort_clr), 32'(on && b == 0));
      if (b > 0) begin
         for (int s = 2; s <= b + 1; s++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (poke && s == 3) begin
               cmd_on = ~on; cmd_sel = 2'b11; cmd_valid = 1'b1;
            end
            if (poke && s == 4) begin
               check(cmd_reject == 1'b1, "R9 reject pulse", 32'(cmd_reject), 32'd1);
               check(gpio_out == first && gpio_oe == eoe, "R9 pins untouched by refused command",
                     32'(gpio_out), 32'(first));
            end
            if (sel == 2'b11 && s == CPM * OMS)
               check(gpio_out[PLL] == 1'b1, "R5 PLL held down during oscillator wait",
                     32'(gpio_out[PLL]), 32'd1);
            if (sel == 2'b11 && s == CPM * OMS + 1)
               check(gpio_out == fin, "R6 PLL released after oscillator wait",
                     32'(gpio_out), 32'(fin));
            if (s == b) begin
               check(busy == 1'b1, "R10 busy through last delay cycle", 32'(busy), 32'd1);
               check(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
            end
            if (s == b + 1) begin
               check(busy == 1'b0, "R10 busy ends on time", 32'(busy), 32'd0);
               check(done && abort_clr, "R8 completion pulses", {done, abort_clr}, 32'd3);
               check(gpio_out == fin, "R8 final pins", 32'(gpio_out), 32'(fin));
            end
         end
      end
      m_out = fin;
      m_oe  = eoe;
      @(negedge clk);
      check(!done && !abort_clr, "R8 pulses last one cycle", {done, abort_clr}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (200_000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4242);
      repeat (4) @(negedge clk);
      check(gpio_out == '0 && gpio_oe == '0, "R1 reset pins", {gpio_out, gpio_oe}, 32'd0);
      check(!busy && !done && !abort_clr && !cmd_reject, "R1 reset strobes",
            {busy, done, abort_clr, cmd_reject}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gpio_out == '0 && !busy, "R1 idle after release", 32'(gpio_out), 32'd0);

      run_cmd(1'b0, 2'b11, 1'b0, 1'b0, "R3");
      run_cmd(1'b1, 2'b11, 1'b1, 1'b0, "R4");
      run_cmd(1'b1, 2'b11, 1'b0, 1'b1, "R5");
      run_cmd(1'b0, 2'b10, 1'b0, 1'b0, "R3");
      run_cmd(1'b1, 2'b10, 1'b0, 1'b1, "R7");
      run_cmd(1'b1, 2'b00, 1'b0, 1'b0, "R11");
      run_cmd(1'b0, 2'b01, 1'b1, 1'b0, "R3");
      run_cmd(1'b1, 2'b01, 1'b0, 1'b1, "R5");

      for (int k = 0; k < 40; k++) begin
         bit on, sense;
         logic [1:0] sel;
         on    = 1'($urandom % 2);
         sense = 1'($urandom % 2);
         sel   = 2'($urandom % 4);
         run_cmd(on, sel, sense, 1'b1, on ? (sense ? "R4" : "R5") : "R3");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule